// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block takes a single-data-rate SDRAM from reset to a usable state. After a synchronous reset it holds the clock enable low and issues only no-operation commands through a long start-up window, raising the clock enable part way through that window. It then issues one precharge of every bank and a programmable number of auto refresh commands. Last comes a load of the mode register, whose value is a parameter. Between commands it waits at least the minimum gap the memory needs. After the final gap it raises `ready` and keeps issuing no-operation commands until the next reset.

Every interval is set in picoseconds together with the clock period. The block turns each one into a whole number of cycles by rounding up, so no gap is ever shorter than its minimum. One down-counter times every wait in turn. All command pins come straight from flip-flops, so each command is valid for one full cycle.

Top module: `sdram_boot_seq`

Edge numbering used below: edge 1 is the first rising clock edge at which `rst` is low. For any time parameter T, the cycle count N(T) is ceil(T / CLK_PERIOD_PS), with a minimum of 1. N_UP is N(T_STARTUP_PS). N_CKE is N(T_CKE_PS) and must be below N_UP. N_RP, N_RFC and N_MRD follow from their own time parameters. A command is written as {cs_n, ras_n, cas_n, we_n}.

## Requirements
- R1: Any clock edge with `rst` high leaves `cke`=0, {cs_n,ras_n,cas_n,we_n}=1111 (command inhibit), `ba`=0, `addr`=0 and `ready`=0.
- R2: `cke` goes high at edge N_CKE and then stays high until the next reset.
- R3: From edge 1 through edge N_UP-1 the command is NOP (0111), with `ba`=0 and `addr`=0.
- R4: At edge N_UP the command is PRECHARGE (0010), with `addr` bit 10 set, all other `addr` bits 0 and `ba`=0.
- R5: The first AUTO REFRESH (0001, `addr`=0, `ba`=0) appears N_RP edges after the precharge. Further refreshes follow every N_RFC edges, for REFRESH_LOOPS refreshes in total (at least two).
- R6: N_RFC edges after the last refresh, the command is LOAD MODE (0000), with `ba`=0 and `addr`=MODE_VALUE.
- R7: Each non-NOP command lasts exactly one cycle. Every cycle after edge 1 that carries no command from R4 to R6 carries NOP with `ba`=0 and `addr`=0.
- R8: `ready` rises N_MRD edges after the LOAD MODE edge. It stays high, with only NOP issued, until the next reset.
- R9: Every wait count is the rounded-up quotient of its time parameter by the clock period. A time that is not a whole number of periods gives one extra cycle.
- R10: A reset in the middle of the sequence restarts it from the CKE-low start state. The whole timeline of R2 to R8 then repeats, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, zero throughout |
| addr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode value for the load |
| ready | output | 1 | High once the sequence has finished |

## Verification
The hardest case to reach from the ports is a reset that lands inside the refresh loop, while the refresh count and the shared timer both hold mid-sequence values. The stimulus runs the sequence up to two cycles past the second refresh and raises `rst` there. It then replays the whole timeline from the new release and compares every cycle with positions computed from the rounded-up wait counts. The bench configuration uses a precharge and a refresh time that are not whole multiples of the clock period, so any truncation in the rounding moves a command by one cycle.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [2:0] {
    PH_UP   = 3'd0,
    PH_RP   = 3'd1,
    PH_RFC  = 3'd2,
    PH_MRD  = 3'd3,
    PH_DONE = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_PRE = 2'd1,
    OP_REF = 2'd2,
    OP_LMR = 2'd3
  } op_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PIN_INHIBIT = 4'b1111;
  localparam logic [3:0] PIN_NOP     = 4'b0111;
  localparam logic [3:0] PIN_PRE     = 4'b0010;
  localparam logic [3:0] PIN_REF     = 4'b0001;
  localparam logic [3:0] PIN_LMR     = 4'b0000;

  localparam int unsigned ALL_BANKS_BIT = 10;

  // Rounded-up conversion of a time into clock cycles, never below one.
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned per_ps);
    longint unsigned q;
    q = (longint'(t_ps) + longint'(per_ps) - 1) / longint'(per_ps);
    if (q == 0) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int unsigned TW      = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] count,
  output logic          zero
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= TW'(RST_VAL);
    end else if (load) begin
      count <= load_val;
    end else if (count != '0) begin
      count <= count - TW'(1);
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/sdram_boot_ctrl.sv
module sdram_boot_ctrl import sdram_boot_pkg::*; #(
  parameter int unsigned TW    = 8,
  parameter int unsigned N_UP  = 4,
  parameter int unsigned N_CKE = 2,
  parameter int unsigned N_RP  = 1,
  parameter int unsigned N_RFC = 1,
  parameter int unsigned N_MRD = 1,
  parameter int unsigned LOOPS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_zero,
  input  logic [TW-1:0] tmr_val,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_load_val,
  output op_t           op,
  output logic          cke_set,
  output logic          rdy_set
);

  localparam int unsigned RW = $clog2(LOOPS + 1);
  localparam logic [TW-1:0] CKE_MARK = TW'(N_UP - N_CKE);

  phase_t        phase, phase_nxt;
  logic [RW-1:0] refs, refs_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_UP;
      refs  <= '0;
    end else begin
      phase <= phase_nxt;
      refs  <= refs_nxt;
    end
  end

  always_comb begin
    phase_nxt    = phase;
    refs_nxt     = refs;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    op           = OP_NOP;
    rdy_set      = 1'b0;
    cke_set      = (phase == PH_UP) && (tmr_val == CKE_MARK);
    if (tmr_zero) begin
      case (phase)
        PH_UP: begin
          op           = OP_PRE;
          tmr_load     = 1'b1;
          tmr_load_val = TW'(N_RP - 1);
          phase_nxt    = PH_RP;
        end
        PH_RP: begin
          op           = OP_REF;
          tmr_load     = 1'b1;
          tmr_load_val = TW'(N_RFC - 1);
          refs_nxt     = RW'(1);
          phase_nxt    = PH_RFC;
        end
        PH_RFC: begin
          tmr_load = 1'b1;
          if (refs < RW'(LOOPS)) begin
            op           = OP_REF;
            tmr_load_val = TW'(N_RFC - 1);
            refs_nxt     = refs + RW'(1);
          end else begin
            op           = OP_LMR;
            tmr_load_val = TW'(N_MRD - 1);
            phase_nxt    = PH_MRD;
          end
        end
        PH_MRD: begin
          rdy_set   = 1'b1;
          phase_nxt = PH_DONE;
        end
        default: begin
          phase_nxt = PH_DONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_boot_drive.sv
module sdram_boot_drive import sdram_boot_pkg::*; #(
  parameter int unsigned          ADDR_W     = 12,
  parameter int unsigned          BA_W       = 2,
  parameter logic [ADDR_W-1:0]    MODE_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  op_t               op,
  input  logic              cke_set,
  input  logic              rdy_set,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANKS_BIT;

  logic [3:0]        pins_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    case (op)
      OP_PRE:  begin pins_nxt = PIN_PRE; addr_nxt = ALL_BANKS;  end
      OP_REF:  begin pins_nxt = PIN_REF; addr_nxt = '0;         end
      OP_LMR:  begin pins_nxt = PIN_LMR; addr_nxt = MODE_VALUE; end
      default: begin pins_nxt = PIN_NOP; addr_nxt = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke                      <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= PIN_INHIBIT;
      ba                       <= '0;
      addr                     <= '0;
      ready                    <= 1'b0;
    end else begin
      cke                      <= cke | cke_set;
      {cs_n, ras_n, cas_n, we_n} <= pins_nxt;
      ba                       <= '0;
      addr                     <= addr_nxt;
      ready                    <= ready | rdy_set;
    end
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq import sdram_boot_pkg::*; #(
  parameter int unsigned       CLK_PERIOD_PS = 7500,
  parameter int unsigned       T_STARTUP_PS  = 100_000_000,
  parameter int unsigned       T_CKE_PS      = 50_000_000,
  parameter int unsigned       T_RP_PS       = 20_000,
  parameter int unsigned       T_RFC_PS      = 66_000,
  parameter int unsigned       T_MRD_PS      = 15_000,
  parameter int unsigned       REFRESH_LOOPS = 2,
  parameter int unsigned       ADDR_W        = 12,
  parameter int unsigned       BA_W          = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE    = 'h030
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int unsigned N_UP_RAW  = cycles_for(T_STARTUP_PS, CLK_PERIOD_PS);
  localparam int unsigned N_UP      = (N_UP_RAW < 2) ? 2 : N_UP_RAW;
  localparam int unsigned N_CKE_RAW = cycles_for(T_CKE_PS, CLK_PERIOD_PS);
  localparam int unsigned N_CKE     = (N_CKE_RAW >= N_UP) ? N_UP - 1 : N_CKE_RAW;
  localparam int unsigned N_RP      = cycles_for(T_RP_PS, CLK_PERIOD_PS);
  localparam int unsigned N_RFC     = cycles_for(T_RFC_PS, CLK_PERIOD_PS);
  localparam int unsigned N_MRD     = cycles_for(T_MRD_PS, CLK_PERIOD_PS);
  localparam int unsigned LOOPS     = (REFRESH_LOOPS < 2) ? 2 : REFRESH_LOOPS;
  localparam int unsigned N_M1      = (N_UP > N_RP) ? N_UP : N_RP;
  localparam int unsigned N_M2      = (N_RFC > N_MRD) ? N_RFC : N_MRD;
  localparam int unsigned N_MAX     = (N_M1 > N_M2) ? N_M1 : N_M2;
  localparam int unsigned TW        = $clog2(N_MAX + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_load_val;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  op_t           op;
  logic          cke_set;
  logic          rdy_set;

  sdram_boot_timer #(
    .TW      (TW),
    .RST_VAL (N_UP - 1)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .count    (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_boot_ctrl #(
    .TW    (TW),
    .N_UP  (N_UP),
    .N_CKE (N_CKE),
    .N_RP  (N_RP),
    .N_RFC (N_RFC),
    .N_MRD (N_MRD),
    .LOOPS (LOOPS)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tmr_zero     (tmr_zero),
    .tmr_val      (tmr_val),
    .tmr_load     (tmr_load),
    .tmr_load_val (tmr_load_val),
    .op           (op),
    .cke_set      (cke_set),
    .rdy_set      (rdy_set)
  );

  sdram_boot_drive #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .MODE_VALUE (MODE_VALUE)
  ) i_drive (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .cke_set (cke_set),
    .rdy_set (rdy_set),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .addr    (addr),
    .ready   (ready)
  );

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int unsigned       ADDR_W     = 12,
  parameter int unsigned       BA_W       = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0,
  parameter int unsigned       RP_CYC     = 1,
  parameter int unsigned       RFC_CYC    = 1,
  parameter int unsigned       MRD_CYC    = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready
);

  logic [3:0]  pins;
  logic        issued;
  logic [3:0]  prev_cmd;
  logic [31:0] gap;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign issued = !cs_n && ({ras_n, cas_n, we_n} != 3'b111);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cmd <= 4'b0111;
      gap      <= '0;
    end else if (issued) begin
      prev_cmd <= pins;
      gap      <= 32'd1;
    end else if (gap != '1) begin
      gap <= gap + 32'd1;
    end
  end

  AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R2

  AST_QUIET_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cke |-> !issued); // R3

  AST_PRECHARGE_ALL: assert property (@(posedge clk) disable iff (rst)
    (issued && pins == 4'b0010) |-> (addr[10] && ba == '0)); // R4

  AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
    (issued && prev_cmd == 4'b0010) |-> (gap >= RP_CYC)); // R5

  AST_RFC_GAP: assert property (@(posedge clk) disable iff (rst)
    (issued && prev_cmd == 4'b0001) |-> (gap >= RFC_CYC)); // R5

  AST_LOAD_BANK0: assert property (@(posedge clk) disable iff (rst)
    (issued && pins == 4'b0000) |-> (ba == '0 && addr == MODE_VALUE)); // R6

  AST_READY_AFTER_MRD: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (prev_cmd == 4'b0000 && gap >= MRD_CYC)); // R8

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8

  AST_READY_SILENT: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!issued && cke)); // R8

endmodule

bind sdram_boot_seq sdram_boot_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .MODE_VALUE (MODE_VALUE),
  .RP_CYC     (N_RP),
  .RFC_CYC    (N_RFC),
  .MRD_CYC    (N_MRD)
) i_chk (
  .clk   (clk),
  .rst   (rst),
  .cke   (cke),
  .cs_n  (cs_n),
  .ras_n (ras_n),
  .cas_n (cas_n),
  .we_n  (we_n),
  .ba    (ba),
  .addr  (addr),
  .ready (ready)
);

// File: tb/test_sdram_boot_seq.sv
`timescale 1ns/1ps
module test_sdram_boot_seq;

  localparam int unsigned PER    = 10_000;
  localparam int unsigned T_UP   = 2_000_000;
  localparam int unsigned T_CKE  = 500_000;
  localparam int unsigned T_RP   = 25_000;
  localparam int unsigned T_RFC  = 65_000;
  localparam int unsigned T_MRD  = 20_000;
  localparam int unsigned LOOPS  = 3;
  localparam int unsigned AW     = 12;
  localparam int unsigned BW     = 2;
  localparam logic [AW-1:0] MODE = 12'h237;

  // expected cycle counts, rounded up (R9)
  localparam int E_UP  = (T_UP  + PER - 1) / PER;
  localparam int E_CKE = (T_CKE + PER - 1) / PER;
  localparam int E_RP  = (T_RP  + PER - 1) / PER;
  localparam int E_RFC = (T_RFC + PER - 1) / PER;
  localparam int E_MRD = (T_MRD + PER - 1) / PER;
  localparam int M_PRE = E_UP;
  localparam int M_REF = M_PRE + E_RP;
  localparam int M_LMR = M_REF + LOOPS * E_RFC;
  localparam int M_RDY = M_LMR + E_MRD;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  sdram_boot_seq #(
    .CLK_PERIOD_PS (PER),
    .T_STARTUP_PS  (T_UP),
    .T_CKE_PS      (T_CKE),
    .T_RP_PS       (T_RP),
    .T_RFC_PS      (T_RFC),
    .T_MRD_PS      (T_MRD),
    .REFRESH_LOOPS (LOOPS),
    .ADDR_W        (AW),
    .BA_W          (BW),
    .MODE_VALUE    (MODE)
  ) i_sdram_boot_seq (
    .clk   (clk),
    .rst   (rst),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr),
    .ready (ready)
  );

  task automatic chk(input bit ok, input string tag, input int m,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s edge %0d act=%h exp=%h", tag, m, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    logic [31:0] act;
    act = {13'd0, cke, cs_n, ras_n, cas_n, we_n, ready, ba, addr};
    chk(act == {13'd0, 1'b0, 4'b1111, 1'b0, {BW{1'b0}}, {AW{1'b0}}},
        tag, 0, act, {13'd0, 1'b0, 4'b1111, 1'b0, {BW{1'b0}}, {AW{1'b0}}});
  endtask

  task automatic step(input int m);
    logic [3:0]    ep;
    logic [AW-1:0] ea;
    string         tag;
    @(posedge clk);
    @(negedge clk);
    ep = 4'b0111; ea = '0;
    tag = (m < M_PRE) ? "R3" : "R7";
    if (m == M_PRE) begin
      ep = 4'b0010; ea = AW'(1) << 10; tag = "R4";
    end else if (m >= M_REF && m < M_LMR && ((m - M_REF) % E_RFC) == 0) begin
      ep = 4'b0001; tag = "R5 R9";
    end else if (m == M_LMR) begin
      ep = 4'b0000; ea = MODE; tag = "R6 R9";
    end
    chk({cs_n, ras_n, cas_n, we_n, ba, addr} == {ep, {BW{1'b0}}, ea}, tag, m,
        32'({cs_n, ras_n, cas_n, we_n, ba, addr}), 32'({ep, {BW{1'b0}}, ea}));
    chk(cke == (m >= E_CKE), "R2", m, 32'(cke), 32'(m >= E_CKE));
    chk(ready == (m >= M_RDY), "R8", m, 32'(ready), 32'(m >= M_RDY));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    for (int m = 1; m <= M_RDY + 12; m++) step(m);

    // reset inside the refresh loop, then replay (R10)
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    for (int m = 1; m <= M_REF + E_RFC + 2; m++) step(m);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R10");
    rst = 1'b0;
    for (int m = 1; m <= M_RDY + 12; m++) step(m);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule